// File: doc/BRIEF.md
# Serial Bank Configuration Port

This block is a slave port on a three-wire serial link: a frame strobe, a bit clock and a data line in, plus one data line out. It holds eight 8-bit configuration banks that a host reaches indirectly. The host first sends an address cycle that loads a bank pointer. It then sends data cycles that write or read the bank that pointer selects. All eight banks drive the rest of the chip in parallel. Bank 0 carries the drive basics: the step-mode field is bits 2:0 (000 = standby), the direction is bit 3 and the torque code is bits 5:4.

Each frame is 16 bits. The first byte is a header and the second byte is the payload. The header holds a fixed 4-bit signature, the 2-bit device identity, a cycle-type flag and a direction flag. A header that fails its check makes the port ignore the payload that follows. The three serial inputs are sampled into the system clock domain, so the bit clock must run well below the system clock.

A fault input gives protection logic a hook. A fault forces the bank 0 step mode to standby and latches a hold flag. That flag clears only when the host rewrites bank 0 with a non-standby mode.

Top module: `serial_bank_port`

## Requirements
- R1: While the strobe `sset` is low, edges on `sclk` change neither the banks nor the pointer.
- R2: Bits are taken on rising `sclk`, MSB first. Sixteen bits form one frame: the header byte first, then the payload byte. Several frames may follow one another inside one strobe-high period.
- R3: The payload is acted on only when header bits 7:4 equal 1011 and header bits 3:2 equal `dev_id` (bit 3 holds the high ID bit). Otherwise nothing changes and `so` stays low.
- R4: Header bit 1 selects the cycle type (0 = address, 1 = data). Header bit 0 selects the direction (0 = write, 1 = read).
- R5: An address write loads payload bits 2:0 into the bank pointer. A data write stores the payload into the bank the pointer selects, and it appears on `cfg_banks[8*k +: 8]` for bank k.
- R6: In a read, `so` presents the value MSB first. The value is the pointer zero-extended to 8 bits for an address read, or the selected bank for a data read. Each bit changes on a falling `sclk` edge, starting with the fall after the eighth header bit, so that each bit is stable across payload rising edges 9 to 16.
- R7: After reset all banks, the pointer, `so` and `fault_hold` are zero.
- R8: `so` is low whenever no read payload is being shifted, including while the strobe is low.
- R9: A fall of the strobe discards a partial frame; the next frame starts again at bit 1.
- R10: A high `fault` clears bank 0 bits 2:0 to standby and sets `fault_hold`.
- R11: `fault_hold` clears only on a bank 0 write whose bits 2:0 are non-zero. A bank 0 write while held stores all of its fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sset | input | 1 | Serial frame strobe, active high |
| sclk | input | 1 | Serial bit clock |
| sdata | input | 1 | Serial data in |
| dev_id | input | 2 | Device identity set by strap |
| fault | input | 1 | Protection fault, synchronous to clk |
| so | output | 1 | Serial data out |
| bank_ptr | output | 3 | Current bank pointer |
| cfg_banks | output | 64 | All banks, bank k in bits 8k+7:8k |
| fault_hold | output | 1 | Fault lock, standby enforced |

## Verification
The hardest condition to reach from the ports is the fault hold. Its release depends on both the fault history and the content of a later serial write. A correct but low-level write to bank 0 must not clear it, while other fields in the same write must still land. The stimulus first runs bank 0 in a live mode, then pulses `fault`. It then writes bank 0 with a standby mode and new torque bits, checks that the hold persists, and finally writes a live mode to release it. The abandoned partial frame is reached by dropping the strobe after ten bits and then sending a clean frame.

// File: rtl/sbp_pkg.sv
// Shared constants and helpers for the serial bank port.
// Assumes a header byte of signature[3:0], id[1:0], data flag, read flag.
package sbp_pkg;
    localparam int HDR_W = 8;
    localparam logic [3:0] SIGNATURE = 4'b1011;

    typedef struct packed {
        logic [3:0] sig;
        logic [1:0] id;
        logic       is_data;
        logic       is_read;
    } hdr_t;

    // True when the header carries the signature and this device's identity.
    function automatic logic hdr_accepts(input hdr_t h, input logic [1:0] id);
        return (h.sig == SIGNATURE) && (h.id == id);
    endfunction
endpackage

// File: rtl/sbp_sync.sv
// Multi-stage synchronizer with rise/fall detection for each bit.
// Assumes inputs are asynchronous and change slower than a few clk cycles.
module sbp_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_sync,
    output logic [WIDTH-1:0] d_rise,
    output logic [WIDTH-1:0] d_fall
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the raw input through the synchronizing chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d_in[b]};
        end

        // Remember the last synchronized value for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) prev <= 1'b0;
            else        prev <= chain[STAGES-1];
        end

        assign d_sync[b] = chain[STAGES-1];
        assign d_rise[b] = chain[STAGES-1] & ~prev;
        assign d_fall[b] = ~chain[STAGES-1] & prev;
    end
endmodule

// File: rtl/sbp_frame.sv
// Frame receiver: counts bits, captures and checks the header, and raises
// one-cycle strobes for read start and write commit.
// Assumes sset/sclk/sdata are already synchronized to clk.
module sbp_frame
    import sbp_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sset_s,
    input  logic             sclk_rise,
    input  logic             sdata_s,
    input  logic [1:0]       dev_id,
    output logic             rd_start,
    output logic             rd_is_data,
    output logic             frame_end,
    output logic             wr_ptr_en,
    output logic             wr_dat_en,
    output logic [REG_W-1:0] wr_byte
);
    localparam int FRAME_W = HDR_W + REG_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int SH_W    = (HDR_W > REG_W ? HDR_W : REG_W) - 1;

    logic [CNT_W-1:0] bit_cnt;
    logic [SH_W-1:0]  sh;
    logic             hdr_ok;
    logic             hdr_data;
    logic             hdr_read;
    logic             take;
    logic             last_hdr_bit;
    logic             last_bit;
    hdr_t             hdr_now;
    logic             hdr_pass;

    assign take         = sset_s & sclk_rise;
    assign last_hdr_bit = take && (bit_cnt == CNT_W'(HDR_W - 1));
    assign last_bit     = take && (bit_cnt == CNT_W'(FRAME_W - 1));
    assign hdr_now      = hdr_t'({sh[HDR_W-2:0], sdata_s});
    assign hdr_pass     = hdr_accepts(hdr_now, dev_id);

    // Bit counter; a low strobe restarts the frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          bit_cnt <= '0;
        else if (!sset_s)    bit_cnt <= '0;
        else if (last_bit)   bit_cnt <= '0;
        else if (take)       bit_cnt <= bit_cnt + 1'b1;
    end

    // Serial shift register holding the bits received so far.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh <= '0;
        else if (take)  sh <= {sh[SH_W-2:0], sdata_s};
    end

    // Header verdict and flags, held for the payload half of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_ok   <= 1'b0;
            hdr_data <= 1'b0;
            hdr_read <= 1'b0;
        end else if (!sset_s || last_bit) begin
            hdr_ok   <= 1'b0;
            hdr_data <= 1'b0;
            hdr_read <= 1'b0;
        end else if (last_hdr_bit) begin
            hdr_ok   <= hdr_pass;
            hdr_data <= hdr_now.is_data;
            hdr_read <= hdr_now.is_read;
        end
    end

    assign rd_start   = last_hdr_bit && hdr_pass && hdr_now.is_read;
    assign rd_is_data = hdr_now.is_data;
    assign frame_end  = last_bit;
    assign wr_ptr_en  = last_bit && hdr_ok && !hdr_read && !hdr_data;
    assign wr_dat_en  = last_bit && hdr_ok && !hdr_read &&  hdr_data;
    assign wr_byte    = {sh[REG_W-2:0], sdata_s};
endmodule

// File: rtl/sbp_banks.sv
// Bank pointer plus the register banks, with the fault hook on bank 0.
// Assumes bank 0 bits MODE_W-1:0 hold the step mode, zero meaning standby.
module sbp_banks #(
    parameter int NUM_BANKS = 8,
    parameter int REG_W     = 8,
    parameter int MODE_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_ptr_en,
    input  logic                       wr_dat_en,
    input  logic [REG_W-1:0]           wr_byte,
    input  logic                       fault,
    output logic [$clog2(NUM_BANKS)-1:0] ptr,
    output logic [REG_W-1:0]           rd_bank,
    output logic [NUM_BANKS*REG_W-1:0] banks_flat,
    output logic                       hold
);
    localparam int PTR_W = $clog2(NUM_BANKS);

    logic [REG_W-1:0] bank_q [NUM_BANKS];
    logic             wr_bank0;
    logic             live_mode;

    assign wr_bank0  = wr_dat_en && (ptr == '0);
    assign live_mode = (wr_byte[MODE_W-1:0] != '0);

    // Bank pointer loaded by address writes.
    always_ff @(posedge clk) begin
        if (!rst_n)         ptr <= '0;
        else if (wr_ptr_en) ptr <= wr_byte[PTR_W-1:0];
    end

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        logic sel;
        assign sel = wr_dat_en && (ptr == PTR_W'(k));
        if (k == 0) begin : g_guarded
            // Bank 0: serial writes, with the mode field forced to standby on fault.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bank_q[k] <= '0;
                end else begin
                    if (sel) bank_q[k] <= wr_byte;
                    if (fault) bank_q[k][MODE_W-1:0] <= '0;
                end
            end
        end else begin : g_plain
            // Other banks: plain serial writes.
            always_ff @(posedge clk) begin
                if (!rst_n)   bank_q[k] <= '0;
                else if (sel) bank_q[k] <= wr_byte;
            end
        end
        assign banks_flat[k*REG_W +: REG_W] = bank_q[k];
    end

    // Fault lock: set by fault, released by a live-mode bank 0 write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold <= 1'b0;
        else if (fault)                 hold <= 1'b1;
        else if (wr_bank0 && live_mode) hold <= 1'b0;
    end

    assign rd_bank = bank_q[ptr];
endmodule

// File: rtl/sbp_shiftout.sv
// Read-back shifter driving the serial output on falling bit-clock edges.
// Assumes the load strobe arrives on the rising edge of the last header bit.
module sbp_shiftout #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sset_s,
    input  logic             sclk_fall,
    input  logic             load,
    input  logic [REG_W-1:0] load_val,
    input  logic             frame_end,
    output logic             so
);
    logic [REG_W-1:0] osh;
    logic             active;

    // Read window: open from header end until frame end or strobe drop.
    always_ff @(posedge clk) begin
        if (!rst_n)                   active <= 1'b0;
        else if (!sset_s || frame_end) active <= 1'b0;
        else if (load)                active <= 1'b1;
    end

    // Output shifter, advanced on each falling bit clock within the window.
    always_ff @(posedge clk) begin
        if (!rst_n)                       osh <= '0;
        else if (load)                    osh <= load_val;
        else if (sclk_fall && active)     osh <= {osh[REG_W-2:0], 1'b0};
    end

    // Output bit: MSB of the shifter during a read, low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)          so <= 1'b0;
        else if (!sset_s)    so <= 1'b0;
        else if (sclk_fall)  so <= active ? osh[REG_W-1] : 1'b0;
    end
endmodule

// File: rtl/serial_bank_port.sv
// Top: three-wire serial slave giving indirect access to configuration banks.
// Assumes the serial clock is slower than clk by well over SYNC_STAGES+2 cycles.
module serial_bank_port #(
    parameter int NUM_BANKS   = 8,
    parameter int REG_W       = 8,
    parameter int MODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sset,
    input  logic                       sclk,
    input  logic                       sdata,
    input  logic [1:0]                 dev_id,
    input  logic                       fault,
    output logic                       so,
    output logic [$clog2(NUM_BANKS)-1:0] bank_ptr,
    output logic [NUM_BANKS*REG_W-1:0] cfg_banks,
    output logic                       fault_hold
);
    localparam int PTR_W = $clog2(NUM_BANKS);

    logic [2:0]       s_sync, s_rise, s_fall;
    logic             sset_s, sclk_rise, sclk_fall, sdata_s;
    logic             rd_start, rd_is_data, frame_end;
    logic             wr_ptr_en, wr_dat_en;
    logic [REG_W-1:0] wr_byte, rd_bank, rd_val;

    sbp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in({sdata, sclk, sset}),
        .d_sync(s_sync), .d_rise(s_rise), .d_fall(s_fall)
    );

    assign sset_s    = s_sync[0];
    assign sclk_rise = s_rise[1];
    assign sclk_fall = s_fall[1];
    assign sdata_s   = s_sync[2];

    sbp_frame #(.REG_W(REG_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .sset_s(sset_s), .sclk_rise(sclk_rise),
        .sdata_s(sdata_s), .dev_id(dev_id), .rd_start(rd_start),
        .rd_is_data(rd_is_data), .frame_end(frame_end),
        .wr_ptr_en(wr_ptr_en), .wr_dat_en(wr_dat_en), .wr_byte(wr_byte)
    );

    sbp_banks #(.NUM_BANKS(NUM_BANKS), .REG_W(REG_W), .MODE_W(MODE_W)) u_banks (
        .clk(clk), .rst_n(rst_n), .wr_ptr_en(wr_ptr_en), .wr_dat_en(wr_dat_en),
        .wr_byte(wr_byte), .fault(fault), .ptr(bank_ptr), .rd_bank(rd_bank),
        .banks_flat(cfg_banks), .hold(fault_hold)
    );

    assign rd_val = rd_is_data ? rd_bank : REG_W'(bank_ptr);

    sbp_shiftout #(.REG_W(REG_W)) u_out (
        .clk(clk), .rst_n(rst_n), .sset_s(sset_s), .sclk_fall(sclk_fall),
        .load(rd_start), .load_val(rd_val), .frame_end(frame_end), .so(so)
    );
endmodule

// File: rtl/sbp_checker.sv
// Property checker for serial_bank_port, attached by bind below.
module sbp_checker #(
    parameter int NUM_BANKS = 8,
    parameter int REG_W     = 8,
    parameter int MODE_W    = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         sset_s,
    input logic                         fault,
    input logic                         so,
    input logic [$clog2(NUM_BANKS)-1:0] bank_ptr,
    input logic [NUM_BANKS*REG_W-1:0]   cfg_banks,
    input logic                         fault_hold
);
    logic [MODE_W-1:0] mode;
    assign mode = cfg_banks[MODE_W-1:0];

    // R1: strobe low and no fault leaves banks and pointer untouched.
    a_r1_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!sset_s && !fault) |=> ($stable(cfg_banks) && $stable(bank_ptr)));

    // R8: serial output drops low once the strobe is low.
    a_r8_so_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !sset_s |=> !so);

    // R10: a fault forces standby and sets the lock.
    a_r10_fault_standby: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (mode == '0) && fault_hold);

    // R11: the lock only falls together with a live mode in bank 0.
    a_r11_release_live: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_hold) |-> (mode != '0));

    // R5: pointer moves only as a result of an accepted frame under strobe.
    a_r5_ptr_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bank_ptr) |-> $past(sset_s));
endmodule

bind serial_bank_port sbp_checker #(
    .NUM_BANKS(NUM_BANKS), .REG_W(REG_W), .MODE_W(MODE_W)
) i_sbp_checker (
    .clk(clk), .rst_n(rst_n), .sset_s(sset_s), .fault(fault), .so(so),
    .bank_ptr(bank_ptr), .cfg_banks(cfg_banks), .fault_hold(fault_hold)
);

// File: tb/test_serial_bank_port.sv
module test_serial_bank_port;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sset = 1'b0, sclk = 1'b0, sdata = 1'b0, fault = 1'b0;
    logic [1:0]  dev_id = 2'b00;
    logic        so;
    logic [2:0]  bank_ptr;
    logic [63:0] cfg_banks;
    logic        fault_hold;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    logic [7:0] exp_bank [8];
    logic [2:0] exp_ptr;

    always #5 clk = ~clk;

    serial_bank_port i_serial_bank_port (
        .clk(clk), .rst_n(rst_n), .sset(sset), .sclk(sclk), .sdata(sdata),
        .dev_id(dev_id), .fault(fault), .so(so), .bank_ptr(bank_ptr),
        .cfg_banks(cfg_banks), .fault_hold(fault_hold)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] hdr(input logic [1:0] id, input bit dat, input bit rd);
        return {4'b1011, id, dat, rd};
    endfunction

    // One 16-bit frame inside an already-high strobe; returns what SO carried.
    task automatic frame_bits(input logic [7:0] h, input logic [7:0] p, output logic [7:0] rd);
        logic [15:0] w;
        w = {h, p};
        rd = '0;
        for (int i = 15; i >= 0; i--) begin
            sclk = 1'b0; sdata = w[i];
            wait_clk(HALF);
            if (i < 8) rd[i] = so;
            sclk = 1'b1;
            wait_clk(HALF);
        end
        sclk = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic xfer(input logic [7:0] h, input logic [7:0] p, output logic [7:0] rd);
        sset = 1'b1; wait_clk(HALF);
        frame_bits(h, p, rd);
        sset = 1'b0; wait_clk(HALF);
    endtask

    task automatic check_banks(input string req);
        for (int k = 0; k < 8; k++) check(req, cfg_banks[8*k +: 8], exp_bank[k]);
        check(req, bank_ptr, exp_ptr);
    endtask

    task automatic t_reset;
        check("R7 ptr", bank_ptr, 0);
        check("R7 banks", cfg_banks, 0);
        check("R7 so", so, 0);
        check("R7 hold", fault_hold, 0);
    endtask

    task automatic t_addr_rw;
        logic [7:0] r;
        xfer(hdr(2'b00, 0, 0), 8'h03, r); exp_ptr = 3;
        check("R5 ptr write", bank_ptr, 3);
        check("R8 so low on write", r, 0);
        xfer(hdr(2'b00, 0, 1), 8'hFF, r);
        check("R6 ptr read", r, 8'h03);
        check("R4 read no change", bank_ptr, 3);
    endtask

    task automatic t_all_banks;
        logic [7:0] r;
        for (int k = 0; k < 8; k++) begin
            xfer(hdr(2'b00, 0, 0), 8'(k), r);
            xfer(hdr(2'b00, 1, 0), 8'(8'h5A ^ (k * 8'h13)), r);
            exp_bank[k] = 8'h5A ^ 8'(k * 8'h13); exp_ptr = 3'(k);
        end
        check_banks("R5 all banks");
        for (int k = 0; k < 8; k++) begin
            xfer(hdr(2'b00, 0, 0), 8'(k), r);
            xfer(hdr(2'b00, 1, 1), 8'h00, r);
            check("R6 data read", r, exp_bank[k]);
        end
    endtask

    task automatic t_bad_header;
        logic [7:0] r;
        xfer(8'b1010_0010, 8'hC3, r);
        check_banks("R3 bad signature");
        xfer(hdr(2'b01, 1, 0), 8'hC3, r);
        check_banks("R3 wrong id");
        xfer(hdr(2'b01, 1, 1), 8'h00, r);
        check("R3 wrong id read so", r, 0);
    endtask

    task automatic t_strobe_low;
        logic [15:0] w;
        w = {hdr(2'b00, 1, 0), 8'h77};
        for (int i = 15; i >= 0; i--) begin
            sclk = 1'b0; sdata = w[i]; wait_clk(HALF);
            sclk = 1'b1; wait_clk(HALF);
        end
        sclk = 1'b0; wait_clk(HALF);
        check_banks("R1 strobe low ignored");
    endtask

    task automatic t_partial;
        logic [7:0] r;
        logic [15:0] w;
        w = {hdr(2'b00, 1, 0), 8'h99};
        sset = 1'b1; wait_clk(HALF);
        for (int i = 15; i >= 6; i--) begin
            sclk = 1'b0; sdata = w[i]; wait_clk(HALF);
            sclk = 1'b1; wait_clk(HALF);
        end
        sclk = 1'b0; wait_clk(HALF);
        sset = 1'b0; wait_clk(HALF);
        check_banks("R9 partial dropped");
        xfer(hdr(2'b00, 0, 0), 8'h06, r); exp_ptr = 6;
        check("R9 clean frame after drop", bank_ptr, 6);
    endtask

    task automatic t_back_to_back;
        logic [7:0] r;
        sset = 1'b1; wait_clk(HALF);
        frame_bits(hdr(2'b00, 0, 0), 8'h02, r);
        frame_bits(hdr(2'b00, 1, 0), 8'hE1, r);
        frame_bits(hdr(2'b00, 1, 1), 8'h00, r);
        sset = 1'b0; wait_clk(HALF);
        exp_ptr = 2; exp_bank[2] = 8'hE1;
        check("R2 back-to-back read", r, 8'hE1);
        check_banks("R2 back-to-back");
        check("R8 so idle", so, 0);
    endtask

    task automatic t_other_id;
        logic [7:0] r;
        dev_id = 2'b10;
        xfer(hdr(2'b10, 0, 0), 8'h01, r); exp_ptr = 1;
        xfer(hdr(2'b10, 1, 0), 8'h3C, r); exp_bank[1] = 8'h3C;
        check_banks("R3 id 10 accepted");
        xfer(hdr(2'b00, 1, 0), 8'hFF, r);
        check_banks("R3 old id rejected");
        dev_id = 2'b00;
    endtask

    task automatic t_fault;
        logic [7:0] r;
        xfer(hdr(2'b00, 0, 0), 8'h00, r); exp_ptr = 0;
        xfer(hdr(2'b00, 1, 0), 8'h2D, r); exp_bank[0] = 8'h2D;
        check("R5 bank0 live", cfg_banks[7:0], 8'h2D);
        fault = 1'b1; wait_clk(1); fault = 1'b0; wait_clk(2);
        exp_bank[0] = 8'h28;
        check("R10 standby forced", cfg_banks[7:0], 8'h28);
        check("R10 hold set", fault_hold, 1);
        xfer(hdr(2'b00, 1, 0), 8'h38, r); exp_bank[0] = 8'h38;
        check("R11 held after standby write", fault_hold, 1);
        check("R11 fields stored while held", cfg_banks[7:0], 8'h38);
        xfer(hdr(2'b00, 1, 0), 8'h13, r); exp_bank[0] = 8'h13;
        check("R11 released", fault_hold, 0);
        check_banks("R11 bank0 live again");
    endtask

    initial begin
        for (int k = 0; k < 8; k++) exp_bank[k] = '0;
        exp_ptr = '0;
        wait_clk(5); rst_n = 1'b1; wait_clk(3);
        t_reset();
        t_addr_rw();
        t_all_banks();
        t_bad_header();
        t_strobe_low();
        t_partial();
        t_back_to_back();
        t_other_id();
        t_fault();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule